// File: doc/BRIEF.md
# FEAC Codeword Receive Detector

This block watches a serial line, one bit per `bit_en` strobe, for the 16-bit far-end alarm codeword. In arrival order a codeword is eight ones, a zero, six data bits and a closing zero. The search moves forward one bit position at a time, so a codeword is found at any alignment. The first match fixes a 16-bit grid, and every later codeword opportunity is taken on that grid.

A codeword counts as present only after the same six data bits arrive at three opportunities in a row. When that happens, a sticky detect flag is set and the data bits are pushed into a four-entry FIFO that the host reads. A present codeword is dropped after two bad receptions in a row. A different valid codeword arriving while one is present counts as a bad reception and also starts a count toward its own validation. When the FIFO is full, a new entry is discarded and a sticky overflow flag is set. The host clears both flags with a single strobe.

Top module: `feac_rx_detector`

## Requirements
- R1: After a synchronous active-low reset, `detect_sts`, `ovf_sts` and `code_present` are 0 and `fifo_empty` is 1.
- R2: A codeword is recognised at any bit alignment, and only bits presented with `bit_en` high are taken. A codeword is, in arrival order, ones in positions 0 to 7, a zero in position 8, data in positions 9 to 14 and a zero in position 15. The data bit that arrives first (position 9) is stored as bit 0 of `rd_data`.
- R3: A codeword is validated on the clock edge that takes the last bit of its third identical consecutive reception. At that edge `detect_sts` and `code_present` rise. After only two receptions, neither is set.
- R4: Before validation, a reception that does not match the candidate sends the block back to the bit-by-bit search, and the count starts again from the next match.
- R5: A validated codeword stays present through one bad reception. It is dropped (`code_present` goes to 0) at the end of the second bad reception in a row. A good reception between bad ones resets this count.
- R6: Each validation writes exactly one FIFO entry. Later repeats of the present codeword write nothing.
- R7: The FIFO holds four entries and returns them oldest first. `rd_data` shows the oldest entry while `fifo_empty` is 0. A `rd_en` pulse removes that entry, and `rd_en` is ignored when the FIFO is empty.
- R8: A validation that occurs while the FIFO holds four entries is discarded, with the stored entries unchanged, and `ovf_sts` is set.
- R9: `detect_sts` and `ovf_sts` stay set until a `clr_sts` pulse clears both of them. If a new event arrives in the same cycle as the clear, the event wins.
- R10: While a codeword is present, a different valid codeword counts as a bad reception of the present one and also counts toward its own validation. Three in a row of the new codeword drop the old one at the second and validate the new one at the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Strobe: take `bit_in` this cycle |
| bit_in | input | 1 | Serial receive data |
| rd_en | input | 1 | Pop the oldest FIFO entry |
| clr_sts | input | 1 | Clear both sticky flags |
| rd_data | output | 6 | Oldest FIFO entry (data bits, first-arrived in bit 0) |
| fifo_empty | output | 1 | FIFO holds no entry |
| detect_sts | output | 1 | Sticky: a codeword was validated |
| ovf_sts | output | 1 | Sticky: a validated codeword was dropped because the FIFO was full |
| code_present | output | 1 | A validated codeword is currently present |

## Verification
A wrong grid position or a wrong repetition count shows at the ports on the same edge where validation should happen or where the codeword should be dropped. `detect_sts` and `code_present` then move one or more codeword periods (16 strobes) early or late. A stuck FIFO pointer or count shows on the next pop, as a wrong `rd_data` or a wrong `fifo_empty`. A wrong drop-on-full rule shows as data out of order or an `ovf_sts` that never rises. The bench compares all four status outputs after every strobe and every FIFO entry at every pop, so a fault shows within one strobe of the cycle it corrupts.

// File: rtl/feac_rx_pkg.sv
// Shared constants and types for the FEAC receive detector.
// Assumes the codeword layout is fixed: a run of ones, a zero,
// the data field, and a closing zero.
package feac_rx_pkg;
    localparam int CW_BITS = 16;   // codeword length in bits
    localparam int FLAG_W  = 8;    // leading run of ones
    localparam int DATA_W  = CW_BITS - FLAG_W - 2;

    typedef logic [DATA_W-1:0] feac_data_t;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_COUNT = 2'd1,
        ST_VALID = 2'd2
    } feac_state_e;
endpackage

// File: rtl/feac_shift_match.sv
// Serial window and codeword pattern match.
// The oldest bit sits at index 0 of the window. Hit and data are
// decoded from the window as it will be after the current bit, so a
// match is reported in the same cycle as the strobe that completes it.
module feac_shift_match
    import feac_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       bit_in,
    output logic       cw_hit,
    output feac_data_t cw_data
);
    logic [CW_BITS-1:0] win_q;
    logic [CW_BITS-1:0] win_nxt;

    assign win_nxt = {bit_in, win_q[CW_BITS-1:1]};

    // Window register: moves one position on each strobe; all ones after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            win_q <= '1;
        else if (bit_en)
            win_q <= win_nxt;
    end

    // Pattern decode on the updated window.
    always_comb begin
        cw_hit  = (win_nxt[FLAG_W-1:0] == '1) && !win_nxt[FLAG_W] && !win_nxt[CW_BITS-1];
        cw_data = win_nxt[CW_BITS-2:FLAG_W+1];
    end
endmodule

// File: rtl/feac_validator.sv
// Validation and loss tracking for received codewords.
// HUNT checks every strobe for a match. COUNT and VALID check only at
// codeword opportunities, spaced CW_BITS strobes apart from the first
// match. While VALID, it also counts an alternative codeword so that a
// new code can take over without returning to the search.
// Assumes CLEAR_CNT < VALID_CNT.
module feac_validator
    import feac_rx_pkg::*;
#(
    parameter int VALID_CNT = 3,
    parameter int CLEAR_CNT = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       cw_hit,
    input  feac_data_t cw_data,
    output logic       present,
    output logic       wr_en,
    output feac_data_t wr_data
);
    localparam int POS_W = $clog2(CW_BITS);
    localparam int RUN_W = $clog2(VALID_CNT + 1);
    localparam int BAD_W = $clog2(CLEAR_CNT + 1);

    feac_state_e      state_q;
    logic [POS_W-1:0] pos_q;
    feac_data_t       cand_q;
    logic [RUN_W-1:0] run_q;
    logic [BAD_W-1:0] bad_q;
    feac_data_t       altc_q;
    logic [RUN_W-1:0] alt_q;

    logic             at_opp;
    logic             same;
    logic             val_now;
    logic [RUN_W-1:0] alt_next;

    // Opportunity, match and validation decode for this strobe.
    always_comb begin
        at_opp   = bit_en && (state_q != ST_HUNT) && (pos_q == POS_W'(CW_BITS - 1));
        same     = cw_hit && (cw_data == cand_q);
        val_now  = at_opp && (state_q == ST_COUNT) && same && (run_q == RUN_W'(VALID_CNT - 1));
        alt_next = ((alt_q != '0) && (cw_data == altc_q)) ? alt_q + RUN_W'(1) : RUN_W'(1);
    end

    assign present = (state_q == ST_VALID);
    assign wr_en   = val_now;
    assign wr_data = cand_q;

    // Hunt, count and loss state machine, advanced only on strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            pos_q   <= '0;
            cand_q  <= '0;
            run_q   <= '0;
            bad_q   <= '0;
            altc_q  <= '0;
            alt_q   <= '0;
        end else if (bit_en) begin
            if (state_q == ST_HUNT) begin
                if (cw_hit) begin
                    state_q <= ST_COUNT;
                    cand_q  <= cw_data;
                    run_q   <= RUN_W'(1);
                    pos_q   <= '0;
                end
            end else begin
                pos_q <= pos_q + POS_W'(1);
                if (at_opp) begin
                    if (state_q == ST_COUNT) begin
                        if (val_now) begin
                            state_q <= ST_VALID;
                            bad_q   <= '0;
                            alt_q   <= '0;
                        end else if (same) begin
                            run_q <= run_q + RUN_W'(1);
                        end else begin
                            state_q <= ST_HUNT;
                        end
                    end else if (same) begin
                        bad_q <= '0;
                        alt_q <= '0;
                    end else if (bad_q == BAD_W'(CLEAR_CNT - 1)) begin
                        bad_q <= '0;
                        alt_q <= '0;
                        if (cw_hit) begin
                            state_q <= ST_COUNT;
                            cand_q  <= cw_data;
                            run_q   <= alt_next;
                        end else begin
                            state_q <= ST_HUNT;
                        end
                    end else begin
                        bad_q <= bad_q + BAD_W'(1);
                        if (cw_hit) begin
                            alt_q  <= alt_next;
                            altc_q <= cw_data;
                        end else begin
                            alt_q <= '0;
                        end
                    end
                end
            end
        end
    end

    AST_RISE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(present) |-> ($past(run_q) == RUN_W'(VALID_CNT - 1)));  // R3
    AST_BAD_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        present |-> (bad_q < BAD_W'(CLEAR_CNT)));  // R5
    AST_WRITE_THEN_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> present);  // R6
    AST_NO_WRITE_WHILE_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        present |-> !wr_en);  // R6
endmodule

// File: rtl/feac_fifo.sv
// Small first-in first-out store for validated codeword data.
// The head entry is always visible on rd_data. A write while full
// and a read while empty are both ignored. Storage has no reset.
module feac_fifo
    import feac_rx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  feac_data_t wr_data,
    input  logic       rd_en,
    output feac_data_t rd_data,
    output logic       empty,
    output logic       full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    feac_data_t       mem_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q;
    logic [PTR_W-1:0] rd_ptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             wr_ok;
    logic             rd_ok;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign wr_ok   = wr_en && !full;
    assign rd_ok   = rd_en && !empty;
    assign rd_data = mem_q[rd_ptr_q];

    // Entry storage written at the tail.
    always_ff @(posedge clk) begin
        if (wr_ok)
            mem_q[wr_ptr_q] <= wr_data;
    end

    // Pointer and occupancy upkeep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (wr_ok) wr_ptr_q <= bump(wr_ptr_q);
            if (rd_ok) rd_ptr_q <= bump(rd_ptr_q);
            case ({wr_ok, rd_ok})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));  // R7
    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> (full && $stable(wr_ptr_q)));  // R8
    AST_EMPTY_READ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !wr_en) |=> (empty && $stable(rd_ptr_q)));  // R7
endmodule

// File: rtl/feac_rx_detector.sv
// FEAC receive detector top: window, validator, FIFO and sticky flags.
// Assumes bit_en marks exactly the bits of the alarm channel and that
// the host reads the FIFO and clears the flags through this port list.
module feac_rx_detector
    import feac_rx_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int VALID_CNT  = 3,
    parameter int CLEAR_CNT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              bit_in,
    input  logic              rd_en,
    input  logic              clr_sts,
    output logic [DATA_W-1:0] rd_data,
    output logic              fifo_empty,
    output logic              detect_sts,
    output logic              ovf_sts,
    output logic              code_present
);
    logic       cw_hit;
    feac_data_t cw_data;
    logic       wr_en;
    feac_data_t wr_data;
    logic       fifo_full;

    feac_shift_match u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .bit_in  (bit_in),
        .cw_hit  (cw_hit),
        .cw_data (cw_data)
    );

    feac_validator #(
        .VALID_CNT (VALID_CNT),
        .CLEAR_CNT (CLEAR_CNT)
    ) u_valid (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .cw_hit  (cw_hit),
        .cw_data (cw_data),
        .present (code_present),
        .wr_en   (wr_en),
        .wr_data (wr_data)
    );

    feac_fifo #(
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .empty   (fifo_empty),
        .full    (fifo_full)
    );

    // Sticky flags: a new event wins over a host clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            detect_sts <= 1'b0;
            ovf_sts    <= 1'b0;
        end else begin
            if (wr_en)        detect_sts <= 1'b1;
            else if (clr_sts) detect_sts <= 1'b0;
            if (wr_en && fifo_full) ovf_sts <= 1'b1;
            else if (clr_sts)       ovf_sts <= 1'b0;
        end
    end

    AST_OVF_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fifo_full) |=> ovf_sts);  // R8
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_sts && !wr_en) |=> (!detect_sts && !ovf_sts));  // R9
    AST_DETECT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (detect_sts && !clr_sts) |=> detect_sts);  // R9
    AST_DETECT_BRINGS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(detect_sts) |-> (!fifo_empty || ovf_sts));  // R6
endmodule

// File: tb/feac_rx_detector_bench.sv
`timescale 1ns/1ps
module feac_rx_detector_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       bit_in = 1'b1;
    logic       rd_en = 1'b0;
    logic       clr_sts = 1'b0;
    logic [5:0] rd_data;
    logic       fifo_empty;
    logic       detect_sts;
    logic       ovf_sts;
    logic       code_present;

    always #2.5 clk = ~clk;

    feac_rx_detector u_feac_rx_detector (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_en       (bit_en),
        .bit_in       (bit_in),
        .rd_en        (rd_en),
        .clr_sts      (clr_sts),
        .rd_data      (rd_data),
        .fifo_empty   (fifo_empty),
        .detect_sts   (detect_sts),
        .ovf_sts      (ovf_sts),
        .code_present (code_present)
    );

    int n_chk = 0;
    int n_err = 0;

    // Requirement model state
    logic [15:0] m_win = 16'hFFFF;
    int          m_st = 0;     // 0 hunt, 1 counting, 2 present
    int          m_pos = 0;
    int          m_run = 0;
    int          m_bad = 0;
    int          m_alt = 0;
    logic [5:0]  m_cand = '0;
    logic [5:0]  m_altc = '0;
    bit          m_det = 0;
    bit          m_ovf = 0;
    logic [5:0]  m_q[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] cw_of(input logic [5:0] d);
        return {1'b0, d, 1'b0, 8'hFF};
    endfunction

    // Model of one accepted bit, written from the requirements.
    task automatic model_bit(input logic b);
        bit         hit;
        bit         opp;
        logic [5:0] d;
        m_win = {b, m_win[15:1]};
        hit   = (m_win[7:0] == 8'hFF) && !m_win[8] && !m_win[15];
        d     = m_win[14:9];
        if (m_st == 0) begin
            if (hit) begin
                m_st = 1; m_cand = d; m_run = 1; m_pos = 0;
            end
        end else begin
            opp   = (m_pos == 15);
            m_pos = (m_pos + 1) % 16;
            if (opp) begin
                if (m_st == 1) begin
                    if (hit && d == m_cand) begin
                        if (m_run == 2) begin
                            m_st = 2; m_bad = 0; m_alt = 0; m_det = 1;
                            if (m_q.size() == 4) m_ovf = 1;
                            else m_q.push_back(d);
                        end else m_run++;
                    end else m_st = 0;
                end else if (hit && d == m_cand) begin
                    m_bad = 0; m_alt = 0;
                end else if (m_bad == 1) begin
                    if (hit) begin
                        m_run = (m_alt > 0 && d == m_altc) ? m_alt + 1 : 1;
                        m_st = 1; m_cand = d;
                    end else m_st = 0;
                    m_bad = 0; m_alt = 0;
                end else begin
                    m_bad++;
                    if (hit) begin
                        m_alt  = (m_alt > 0 && d == m_altc) ? m_alt + 1 : 1;
                        m_altc = d;
                    end else m_alt = 0;
                end
            end
        end
    endtask

    task automatic cmp_all();
        chk(code_present == (m_st == 2), "R5 code_present vs model", int'(code_present), int'(m_st == 2));
        chk(detect_sts == m_det, "R3 detect_sts vs model", int'(detect_sts), int'(m_det));
        chk(ovf_sts == m_ovf, "R8 ovf_sts vs model", int'(ovf_sts), int'(m_ovf));
        chk(fifo_empty == (m_q.size() == 0), "R7 fifo_empty vs model", int'(fifo_empty), int'(m_q.size() == 0));
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_en = 1'b1;
        bit_in = b;
        @(negedge clk);
        bit_en = 1'b0;
        bit_in = 1'b0;  // value while idle must be ignored (R2)
        model_bit(b);
        cmp_all();
    endtask

    task automatic send_cw(input logic [5:0] d, input int reps);
        for (int r = 0; r < reps; r++) begin
            logic [15:0] w;
            w = cw_of(d);
            for (int i = 0; i < 16; i++) send_bit(w[i]);
        end
    endtask

    task automatic send_ones(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b1);
    endtask

    task automatic read_one();
        @(negedge clk);
        chk(!fifo_empty, "R7 entry expected", int'(fifo_empty), 0);
        chk(rd_data == m_q[0], "R7 head entry", int'(rd_data), int'(m_q[0]));
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        void'(m_q.pop_front());
        cmp_all();
    endtask

    task automatic clear_flags();
        @(negedge clk);
        clr_sts = 1'b1;
        @(negedge clk);
        clr_sts = 1'b0;
        m_det = 0;
        m_ovf = 0;
        chk(!detect_sts && !ovf_sts, "R9 flags cleared", int'({detect_sts, ovf_sts}), 0);
    endtask

    localparam logic [5:0] CODE_A = 6'b000011;
    localparam logic [5:0] CODE_B = 6'b101010;

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!detect_sts && !ovf_sts && !code_present, "R1 flags after reset",
            int'({detect_sts, ovf_sts, code_present}), 0);
        chk(fifo_empty, "R1 fifo empty after reset", int'(fifo_empty), 1);

        // R2 / R3: odd alignment, two copies not enough, third validates
        send_ones(3);
        send_bit(1'b0);
        send_ones(5);
        send_cw(CODE_A, 2);
        chk(!detect_sts && !code_present, "R3 not validated after two", int'(detect_sts), 0);
        send_cw(CODE_A, 1);
        chk(detect_sts && code_present, "R3 validated on third", int'({detect_sts, code_present}), 3);
        chk(rd_data == CODE_A, "R2 first data bit in LSB", int'(rd_data), int'(CODE_A));

        // R6: repeats do not add entries
        send_cw(CODE_A, 3);
        read_one();
        chk(fifo_empty, "R6 single entry per validation", int'(fifo_empty), 1);

        // R5: one bad tolerated, good resets, two bad drop
        send_ones(16);
        chk(code_present, "R5 present after one bad", int'(code_present), 1);
        send_cw(CODE_A, 1);
        send_ones(16);
        chk(code_present, "R5 good reception reset bad count", int'(code_present), 1);
        send_ones(16);
        chk(!code_present, "R5 dropped after two bad", int'(code_present), 0);

        // R9: flag sticky until cleared
        send_ones(20);
        chk(detect_sts, "R9 detect stays set", int'(detect_sts), 1);
        clear_flags();

        // R4: mismatch before validation restarts the count
        send_cw(CODE_A, 2);
        send_ones(16);
        send_cw(CODE_A, 2);
        chk(!detect_sts, "R4 count restarted after mismatch", int'(detect_sts), 0);
        send_cw(CODE_A, 1);
        chk(detect_sts, "R4 validated after fresh three", int'(detect_sts), 1);

        // R10: different code takes over
        send_cw(CODE_B, 1);
        chk(code_present, "R10 one different code tolerated", int'(code_present), 1);
        send_cw(CODE_B, 1);
        chk(!code_present, "R10 old code dropped at second", int'(code_present), 0);
        send_cw(CODE_B, 1);
        chk(code_present, "R10 new code validated at third", int'(code_present), 1);
        chk(rd_data == CODE_A, "R10 older entry first", int'(rd_data), int'(CODE_A));
        read_one();
        chk(rd_data == CODE_B, "R10 new code queued", int'(rd_data), int'(CODE_B));
        read_one();

        // R7 / R8: five validations into four entries
        clear_flags();
        for (int k = 1; k <= 5; k++) send_cw(6'(k), 3);
        chk(ovf_sts, "R8 overflow on fifth", int'(ovf_sts), 1);
        for (int k = 1; k <= 4; k++) begin
            chk(rd_data == 6'(k), "R8 stored entries kept in order", int'(rd_data), k);
            read_one();
        end
        chk(fifo_empty, "R7 empty after four reads", int'(fifo_empty), 1);
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk(fifo_empty, "R7 read on empty ignored", int'(fifo_empty), 1);
        clear_flags();

        // Random mix checked against the model
        for (int it = 0; it < 300; it++) begin
            logic [5:0] d;
            int         reps;
            int         nj;
            d    = 6'($urandom() % 8);
            reps = 1 + int'($urandom() % 4);
            send_cw(d, reps);
            nj = int'($urandom() % 24);
            for (int j = 0; j < nj; j++) send_bit(($urandom() % 4) != 0);
            if (($urandom() % 3) == 0 && m_q.size() > 0) read_one();
            if (($urandom() % 10) == 0) clear_flags();
        end
        while (m_q.size() > 0) read_one();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule